// File: doc/BRIEF.md
# SPI Register-Access Slave Port

This block is a serial slave port that gives an external SPI master byte-level write access and word-level read access to a small bank of 16-bit registers. Every transaction is one 16-bit frame. The frame carries a direction flag, a 7-bit byte address and one data byte. The port runs in SPI mode 3: the clock idles high, input is captured on rising edges and output changes on falling edges. All pins are brought into the system clock domain by synchronisers. The system clock must run at least eight times faster than the serial clock.

A write frame changes one byte of one register. Even addresses select the low byte and odd addresses select the high byte. Reads are pipelined. A read frame only names the word. The word is captured when that frame ends and is shifted out, MSB first, during the next frame. Either byte address of a register returns the full word.

One register slot holds self-clearing command bits. Writing a 1 starts an action, which appears on `cmd_o`. The bit stays set until the core reports completion on `cmd_done_i`. The data output has a separate enable, so the pad can go high-impedance while the slave is deselected.

Top module: `spi_regport`

## Requirements
- R1: Frames are 16 bits in SPI mode 3. DIN is captured on SCLK rising edges, most significant bit first. DOUT stays stable while SCLK is high.
- R2: Frame bit 15 is the direction (1 = write, 0 = read). Bits 14:8 are the byte address. Bits 7:0 are the data byte.
- R3: A write frame updates only the addressed byte and leaves the other byte of that word unchanged. An even address selects bits 7:0 and an odd address selects bits 15:8 of word address[6:1].
- R4: A read frame captures word address[6:1] at its end. The next frame shifts that word out MSB first. The MSB is valid after CS falls and before the first SCLK falling edge, and each later bit follows an SCLK falling edge.
- R5: A read through the odd byte address returns the same 16-bit word as a read through the even byte address.
- R6: `dout_oe_o` is 0 while CS is high and 1 while CS is low.
- R7: A frame that ends with CS rising before the 16th SCLK rising edge is discarded and writes nothing.
- R8: Word CMD_IDX (default 7, byte addresses 0x0E/0x0F) holds the command bits. Writing a byte sets each bit written as 1 and leaves the bits written as 0 unchanged. The result shows on `cmd_o` within 6 system clocks of the 16th SCLK rising edge, while CS is still low. Reading the register returns the pending bits.
- R9: A pending command bit clears after its `cmd_done_i` bit is high for one system clock.
- R10: Word indexes at or above NREG (default 8) ignore writes and read as 0x0000.
- R11: The frame that follows a write frame shifts out 0x0000.
- R12: After reset, all registers and `cmd_o` are 0, and the first frame shifts out 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial data from the master |
| dout_o | output | 1 | Serial data to the master |
| dout_oe_o | output | 1 | Output enable for the DOUT pad |
| cmd_o | output | 16 | Pending command bits |
| cmd_done_i | input | 16 | Per-bit completion strobes from the core |

## Verification
The assertions take three things about the inputs for granted:
- CS stays low for at least one system clock after the synchronised 16th rising edge.
- Each SCLK level lasts several system clocks.
- `cmd_done_i` and a write to the command word do not arrive in the same cycle, except where the checks allow for it.

The stimulus keeps within these limits by design. Each SCLK half-period is 8 system clocks, CS has 8-clock guard gaps on both sides of every frame, and `cmd_done_i` is pulsed only between frames.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned ADDR_W  = 7;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 2 * BYTE_W;
  localparam int unsigned WIDX_W  = ADDR_W - 1;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic cs_s_o,
  output logic din_s_o,
  output logic cs_fall_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  logic [STAGES-1:0] cs_q, sclk_q, din_q;
  logic cs_p, sclk_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '1;
      sclk_q <= '1;
      din_q  <= '0;
      cs_p   <= 1'b1;
      sclk_p <= 1'b1;
    end else begin
      cs_q   <= {cs_q[STAGES-2:0], cs_ni};
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      din_q  <= {din_q[STAGES-2:0], din_i};
      cs_p   <= cs_q[STAGES-1];
      sclk_p <= sclk_q[STAGES-1];
    end
  end

  assign cs_s_o      = cs_q[STAGES-1];
  assign din_s_o     = din_q[STAGES-1];
  assign cs_fall_o   = !cs_q[STAGES-1] && cs_p;
  assign sclk_rise_o = !cs_q[STAGES-1] && sclk_q[STAGES-1] && !sclk_p;
  assign sclk_fall_o = !cs_q[STAGES-1] && !sclk_q[STAGES-1] && sclk_p;
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              dout_o,
  output logic              frame_vld_o,
  output frame_t            frame_o
);
  localparam int unsigned      CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q;
  logic [WORD_W-1:0]  tx_q;
  logic               vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (cs_fall_i) begin
        cnt_q <= '0;
        tx_q  <= tx_word_i;
      end else begin
        if (sclk_rise_i && cnt_q != CNT_FULL) begin
          rx_q  <= {rx_q[FRAME_W-2:0], din_i};
          cnt_q <= cnt_q + 1'b1;
          vld_q <= (cnt_q == CNT_LAST);
        end
        // first falling edge precedes any capture: MSB already on the line
        if (sclk_fall_i && cnt_q != '0 && cnt_q != CNT_FULL)
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign dout_o      = tx_q[WORD_W-1];
  assign frame_vld_o = vld_q;
  assign frame_o     = frame_t'(rx_q);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R1
  AST_FRAME_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> cnt_q == CNT_FULL); // R7
  AST_DONE_WHILE_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> !cs_s_i); // R7
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R1
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter int unsigned NREG    = 8,
  parameter int unsigned CMD_IDX = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic              hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [WIDX_W-1:0] ridx_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [WORD_W-1:0] cmd_done_i,
  output logic [WORD_W-1:0] cmd_o
);
  localparam int unsigned AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0][WORD_W-1:0] word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              sel;
    logic [WORD_W-1:0] q;
    assign sel     = wr_en_i && (widx_i == WIDX_W'(g));
    assign word[g] = q;

    if (g == CMD_IDX) begin : g_cmd
      logic [WORD_W-1:0] set;
      assign set = !sel ? '0 : (hi_i ? {wdata_i, {BYTE_W{1'b0}}}
                                     : {{BYTE_W{1'b0}}, wdata_i});
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= (q & ~cmd_done_i) | set;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (sel) begin
          if (hi_i) q[WORD_W-1:BYTE_W] <= wdata_i;
          else      q[BYTE_W-1:0]      <= wdata_i;
        end
      end
    end
  end

  assign rdata_o = (int'(ridx_i) < NREG) ? word[ridx_i[AW-1:0]] : '0;
  assign cmd_o   = word[CMD_IDX];

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && cmd_done_i == '0) |=> $stable(cmd_o)); // R8
  AST_CMD_NO_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_done_i == '0) |=> ((cmd_o & $past(cmd_o)) == $past(cmd_o))); // R8
  AST_CMD_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((cmd_o & $past(cmd_done_i)) == '0)); // R9
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned NREG        = 8,
  parameter int unsigned CMD_IDX     = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [WORD_W-1:0] cmd_o,
  input  logic [WORD_W-1:0] cmd_done_i
);
  logic              cs_s, din_s, cs_fall, sclk_rise, sclk_fall;
  logic              frame_vld;
  frame_t            frame;
  logic [WORD_W-1:0] rdata, tx_next_q;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i,
    .cs_s_o(cs_s), .din_s_o(din_s), .cs_fall_o(cs_fall),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall)
  );

  spi_regport_frame u_frame (
    .clk_i, .rst_ni,
    .cs_s_i(cs_s), .cs_fall_i(cs_fall), .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall), .din_i(din_s), .tx_word_i(tx_next_q),
    .dout_o, .frame_vld_o(frame_vld), .frame_o(frame)
  );

  spi_regport_regs #(.NREG(NREG), .CMD_IDX(CMD_IDX)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(frame_vld && frame.wr),
    .widx_i(frame.addr[ADDR_W-1:1]),
    .hi_i(frame.addr[0]),
    .wdata_i(frame.data),
    .ridx_i(frame.addr[ADDR_W-1:1]),
    .rdata_o(rdata),
    .cmd_done_i, .cmd_o
  );

  // word for the next frame: snapshot on read, zero after write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tx_next_q <= '0;
    else if (frame_vld) tx_next_q <= frame.wr ? '0 : rdata;
  end

  assign dout_oe_o = !cs_s;

  AST_TX_ONLY_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |=> $stable(tx_next_q)); // R4
endmodule

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic        dout, dout_oe;
  logic [15:0] cmd, cmd_done = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] frm_cmd;
  bit          frm_glitch, frm_oe_bad;

  always #2.5 clk = ~clk;

  spi_regport u_spi_regport (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .cmd_o(cmd), .cmd_done_i(cmd_done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    frm_glitch = 0;
    frm_oe_bad = 0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din  = tx[15-i];
      repeat (8) @(negedge clk);
      rx[15-i] = dout;
      if (!dout_oe) frm_oe_bad = 1;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      if (dout !== rx[15-i]) frm_glitch = 1;
      frm_cmd = cmd;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    logic [15:0] r;
    spi_frame({1'b1, a, d}, 16, r);
  endtask

  task automatic rd_word(input logic [6:0] a, output logic [15:0] w);
    logic [15:0] r;
    spi_frame({1'b0, a, 8'h00}, 16, r);
    spi_frame(16'h0000, 16, w);
  endtask

  task automatic t_reset;
    logic [15:0] r;
    chk("R12 cmd_o after reset", cmd, 16'h0000);
    chk("R6 oe while deselected", {15'd0, dout_oe}, 16'h0000);
    spi_frame(16'h0000, 16, r);
    chk("R12 first frame output", r, 16'h0000);
    chk("R6 oe while selected", {15'd0, frm_oe_bad}, 16'h0000);
    chk("R6 oe after deselect", {15'd0, dout_oe}, 16'h0000);
    rd_word(7'h0C, r);
    chk("R12 register reset value", r, 16'h0000);
  endtask

  task automatic t_bytes;
    logic [15:0] r;
    wr_byte(7'h02, 8'h34);
    wr_byte(7'h03, 8'h12);
    rd_word(7'h02, r);
    chk("R2 R3 word1 via even addr", r, 16'h1234);
    chk("R1 R4 dout stable while sclk high", {15'd0, frm_glitch}, 16'h0000);
    rd_word(7'h03, r);
    chk("R5 word1 via odd addr", r, 16'h1234);
    wr_byte(7'h03, 8'hAB);
    rd_word(7'h02, r);
    chk("R3 high byte only", r, 16'hAB34);
    wr_byte(7'h0A, 8'hC3);
    wr_byte(7'h0B, 8'hA5);
    rd_word(7'h0B, r);
    chk("R3 R5 word5", r, 16'hA5C3);
    rd_word(7'h03, r);
    chk("R3 word1 untouched by word5", r, 16'hAB34);
  endtask

  task automatic t_pipeline;
    logic [15:0] r1, r2, r3;
    spi_frame({1'b0, 7'h02, 8'h00}, 16, r1);
    spi_frame({1'b0, 7'h0A, 8'h00}, 16, r2);
    spi_frame({1'b0, 7'h03, 8'h00}, 16, r3);
    chk("R4 pipelined read 1", r2, 16'hAB34);
    chk("R4 pipelined read 2", r3, 16'hA5C3);
    chk("R1 R4 no glitch in stream", {15'd0, frm_glitch}, 16'h0000);
  endtask

  task automatic t_after_write;
    logic [15:0] r;
    spi_frame({1'b0, 7'h0A, 8'h00}, 16, r);
    spi_frame({1'b1, 7'h08, 8'h77}, 16, r);
    chk("R4 read before write", r, 16'hA5C3);
    spi_frame(16'h0000, 16, r);
    chk("R11 frame after write", r, 16'h0000);
  endtask

  task automatic t_abort;
    logic [15:0] r;
    spi_frame({1'b1, 7'h02, 8'hEE}, 10, r);
    spi_frame({1'b1, 7'h03, 8'hEE}, 15, r);
    rd_word(7'h02, r);
    chk("R7 aborted frames discarded", r, 16'hAB34);
  endtask

  task automatic t_range;
    logic [15:0] r;
    wr_byte(7'h20, 8'h5A);
    wr_byte(7'h7F, 8'h5A);
    rd_word(7'h20, r);
    chk("R10 out-of-range read", r, 16'h0000);
    rd_word(7'h7E, r);
    chk("R10 top word read", r, 16'h0000);
    rd_word(7'h00, r);
    chk("R10 word0 not aliased", r, 16'h0000);
  endtask

  task automatic t_cmd;
    logic [15:0] r;
    spi_frame({1'b1, 7'h0E, 8'h05}, 16, r);
    chk("R8 cmd_o set before CS rises", frm_cmd, 16'h0005);
    wr_byte(7'h0E, 8'h00);
    chk("R8 zero write keeps bits", cmd, 16'h0005);
    wr_byte(7'h0F, 8'h80);
    chk("R8 high byte set", cmd, 16'h8005);
    rd_word(7'h0F, r);
    chk("R8 cmd readback", r, 16'h8005);
    @(negedge clk) cmd_done = 16'h0001;
    @(negedge clk) cmd_done = 16'h0000;
    @(negedge clk);
    chk("R9 done clears bit0", cmd, 16'h8004);
    @(negedge clk) cmd_done = 16'h8004;
    @(negedge clk) cmd_done = 16'h0000;
    @(negedge clk);
    chk("R9 done clears rest", cmd, 16'h0000);
    rd_word(7'h0E, r);
    chk("R9 cmd readback cleared", r, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bytes();
    t_pipeline();
    t_after_write();
    t_abort();
    t_range();
    t_cmd();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule